// File: doc/BRIEF.md
# Double-Buffered Dual-Channel Converter Register Front End

This block is the digital register file in front of a two-channel 12-bit converter. A host with an 8-bit parallel bus fills each channel's code in two bus cycles: one carries the eight low-order bits and one carries the four high-order bits, right-justified on the lowest four data lines. The bytes land in staging registers. The code values that drive the converters stay unchanged until a commit strobe copies both channels' staged words at the same clock edge, so the two outputs change together.

Every control strobe is active low. A bus cycle counts only on the clock edge at which the write strobe is first seen low. Because of this, a write strobe held low for many clock cycles acts exactly once. An asynchronous clear input zeroes every staging register and both output codes at once. A synchronous active-high reset does the same on a clock edge.

Top module: `dual_dac_regfile`

## Requirements
- R1: With `sel_n` low and a write accepted, address 2'b00 loads `bus_data[7:0]` into bits 7:0 of channel A's staged word, and address 2'b10 does the same for channel B. Bit 1 of the address picks the channel (0 = A, 1 = B) and bit 0 picks the half (0 = low byte, 1 = high nibble).
- R2: Addresses 2'b01 (channel A) and 2'b11 (channel B) load `bus_data[3:0]` into bits 11:8 of the staged word. `bus_data[7:4]` has no effect on these writes.
- R3: When `sel_n` is high, an accepted write loads no staging register.
- R4: A write is accepted only on the first clock edge at which `wstb_n` is sampled low after being sampled high. Holding `wstb_n` low longer causes no further load, even if the data changes.
- R5: An accepted write with `commit_n` low copies both channels' staged words into `code_a` and `code_b` on the same clock edge. The outputs are valid after that edge.
- R6: Staging loads without a commit leave `code_a` and `code_b` unchanged.
- R7: When `sel_n`, `commit_n` and `wstb_n` are all low in the accepted cycle, the addressed staging register loads first. The outputs then show the staged word that includes the new byte, after that same edge.
- R8: `zero_n` low clears every staging register and both outputs at once, with no clock edge needed, regardless of the other inputs.
- R9: `rst` high at a clock edge clears every staging register and both outputs.
- R10: With `wstb_n` held high, neither staging registers nor outputs change, whatever the levels of `sel_n` and `commit_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, synchronous with the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| zero_n | input | 1 | Asynchronous active-low clear of all registers |
| sel_n | input | 1 | Active-low select for staging loads |
| wstb_n | input | 1 | Active-low write strobe, edge-qualified |
| commit_n | input | 1 | Active-low commit of staged words to outputs |
| bus_addr | input | 2 | Bit 1 selects the channel, bit 0 selects low byte or high nibble |
| bus_data | input | 8 | Parallel data bus |
| code_a | output | 12 | Registered code for channel A |
| code_b | output | 12 | Registered code for channel B |

## Verification
A staging load and a commit take effect on the same clock edge: the one at which `wstb_n` is first sampled low. Outputs settle one register stage after that edge. The bench drives each bus cycle on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Staging contents cannot be read directly, so they are checked through a later commit-only cycle. The asynchronous clear is checked a few nanoseconds after `zero_n` falls, while the clock is still low, to show that no edge was needed.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int unsigned LO_BITS  = 8;
  localparam int unsigned HI_BITS  = 4;
  localparam int unsigned NUM_CHAN = 2;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/wr_edge_qual.sv
module wr_edge_qual (
  input  logic clk,
  input  logic rst,
  input  logic wstb_n,
  output logic accept
);
  logic wstb_q;

  always_ff @(posedge clk) begin
    if (rst) wstb_q <= 1'b1;
    else     wstb_q <= wstb_n;
  end

  assign accept = wstb_q & ~wstb_n;

  // one accepted write per low period of the strobe
  assert_single_accept_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);
endmodule

// File: rtl/chan_stage_reg.sv
module chan_stage_reg #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 4,
  localparam int unsigned WORD_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [LO_W-1:0]   din,
  output logic [WORD_W-1:0] word_q,
  output logic [WORD_W-1:0] word_fwd
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge zero_n) begin
    if (!zero_n)    lo_q <= '0;
    else if (rst)   lo_q <= '0;
    else if (ld_lo) lo_q <= din;
  end

  always_ff @(posedge clk or negedge zero_n) begin
    if (!zero_n)    hi_q <= '0;
    else if (rst)   hi_q <= '0;
    else if (ld_hi) hi_q <= din[HI_W-1:0];
  end

  assign word_q   = {hi_q, lo_q};
  assign word_fwd = {ld_hi ? din[HI_W-1:0] : hi_q, ld_lo ? din : lo_q};

  assert_nibble_right_just_R2: assert property (@(posedge clk) disable iff (rst || !zero_n)
    ld_hi |=> (hi_q == $past(din[HI_W-1:0])));

  assert_no_stage_change_R3: assert property (@(posedge clk) disable iff (rst || !zero_n)
    !(ld_lo || ld_hi) |=> $stable(word_q));
endmodule

// File: rtl/code_hold_reg.sv
module code_hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zero_n,
  input  logic         xfer,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge zero_n) begin
    if (!zero_n)   q <= '0;
    else if (rst)  q <= '0;
    else if (xfer) q <= d;
  end

  assert_hold_no_commit_R6: assert property (@(posedge clk) disable iff (rst || !zero_n)
    !xfer |=> $stable(q));

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (rst)
    !zero_n |-> (q == '0));
endmodule

// File: rtl/dual_dac_regfile.sv
module dual_dac_regfile #(
  parameter int unsigned LO_W = dacreg_pkg::LO_BITS,
  parameter int unsigned HI_W = dacreg_pkg::HI_BITS,
  localparam int unsigned WORD_W = LO_W + HI_W,
  localparam int unsigned NCH = dacreg_pkg::NUM_CHAN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_n,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              commit_n,
  input  logic [1:0]        bus_addr,
  input  logic [LO_W-1:0]   bus_data,
  output logic [WORD_W-1:0] code_a,
  output logic [WORD_W-1:0] code_b
);
  import dacreg_pkg::*;

  logic accept;
  logic stage_wr;
  logic xfer;
  logic [WORD_W-1:0] stage_q   [NCH];
  logic [WORD_W-1:0] stage_fwd [NCH];
  logic [WORD_W-1:0] code_q    [NCH];

  wr_edge_qual u_edge (
    .clk    (clk),
    .rst    (rst),
    .wstb_n (wstb_n),
    .accept (accept)
  );

  assign stage_wr = accept & ~sel_n;
  assign xfer     = accept & ~commit_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic chan_hit;
    logic ld_lo;
    logic ld_hi;

    assign chan_hit = stage_wr && (bus_addr[1] == 1'(ch));
    assign ld_lo    = chan_hit && (bus_addr[0] == HALF_LO);
    assign ld_hi    = chan_hit && (bus_addr[0] == HALF_HI);

    chan_stage_reg #(.LO_W(LO_W), .HI_W(HI_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .zero_n   (zero_n),
      .ld_lo    (ld_lo),
      .ld_hi    (ld_hi),
      .din      (bus_data),
      .word_q   (stage_q[ch]),
      .word_fwd (stage_fwd[ch])
    );

    code_hold_reg #(.W(WORD_W)) u_code (
      .clk    (clk),
      .rst    (rst),
      .zero_n (zero_n),
      .xfer   (xfer),
      .d      (stage_fwd[ch]),
      .q      (code_q[ch])
    );

    // after a commit the output equals the staged word, including a same-cycle load
    assert_commit_matches_stage_R5: assert property (@(posedge clk) disable iff (rst || !zero_n)
      xfer |=> (code_q[ch] == stage_q[ch]));
  end

  assign code_a = code_q[0];
  assign code_b = code_q[1];

  assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (rst || !zero_n)
    wstb_n |=> ($stable(code_a) && $stable(code_b)));
endmodule

// File: tb/tb_dual_dac_regfile.sv
module tb_dual_dac_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        zero_n = 1'b1;
  logic        sel_n = 1'b1;
  logic        wstb_n = 1'b1;
  logic        commit_n = 1'b1;
  logic [1:0]  bus_addr = 2'b00;
  logic [7:0]  bus_data = 8'h00;
  logic [11:0] code_a;
  logic [11:0] code_b;

  int checks = 0;
  int failures = 0;

  logic [7:0]  m_lo  [2];
  logic [3:0]  m_hi  [2];
  logic [11:0] m_out [2];

  dual_dac_regfile dut (
    .clk(clk), .rst(rst), .zero_n(zero_n), .sel_n(sel_n), .wstb_n(wstb_n),
    .commit_n(commit_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .code_a(code_a), .code_b(code_b)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%03h expected=%03h", tag, got, exp);
    end
  endtask

  task automatic chk_both(input string tag);
    chk({tag, " ch A"}, code_a, m_out[0]);
    chk({tag, " ch B"}, code_b, m_out[1]);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0;
    end
  endtask

  // one accepted bus cycle: strobe low for exactly one rising edge
  task automatic bus_cycle(input logic s_n, input logic c_n, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel_n = s_n; commit_n = c_n; bus_addr = a; bus_data = d; wstb_n = 1'b0;
    @(negedge clk);
    wstb_n = 1'b1; sel_n = 1'b1; commit_n = 1'b1;
    if (!s_n) begin
      if (a[0]) m_hi[a[1]] = d[3:0];
      else      m_lo[a[1]] = d;
    end
    if (!c_n) for (int i = 0; i < 2; i++) m_out[i] = {m_hi[i], m_lo[i]};
  endtask

  task automatic t_reset();
    chk_both("R9 reset state");
  endtask

  task automatic t_staged_then_commit();
    bus_cycle(1'b0, 1'b1, 2'b00, 8'hA5);
    bus_cycle(1'b0, 1'b1, 2'b01, 8'hF3);
    bus_cycle(1'b0, 1'b1, 2'b10, 8'h3C);
    bus_cycle(1'b0, 1'b1, 2'b11, 8'h69);
    chk_both("R6 staging without commit");
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    chk("R1 R2 R5 commit ch A", code_a, 12'h3A5);
    chk("R1 R2 R5 commit ch B", code_b, 12'h93C);
  endtask

  task automatic t_select_high();
    bus_cycle(1'b1, 1'b1, 2'b00, 8'hFF);
    bus_cycle(1'b1, 1'b1, 2'b11, 8'hFF);
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    chk_both("R3 select high loads nothing");
  endtask

  task automatic t_strobe_idle();
    @(negedge clk);
    sel_n = 1'b0; commit_n = 1'b0; bus_addr = 2'b10; bus_data = 8'h77;
    repeat (3) @(negedge clk);
    chk_both("R10 strobe high no change");
    sel_n = 1'b1; commit_n = 1'b1;
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    chk_both("R10 staging untouched");
  endtask

  task automatic t_held_strobe();
    @(negedge clk);
    sel_n = 1'b0; bus_addr = 2'b00; bus_data = 8'h11; wstb_n = 1'b0;
    @(negedge clk); bus_data = 8'h22;
    @(negedge clk); bus_data = 8'h33; bus_addr = 2'b01;
    @(negedge clk); wstb_n = 1'b1; sel_n = 1'b1;
    m_lo[0] = 8'h11;
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    chk("R4 held strobe loads once", code_a, 12'h311);
  endtask

  task automatic t_combined();
    bus_cycle(1'b0, 1'b0, 2'b11, 8'hFE);
    chk("R7 same-cycle load and commit ch B", code_b, 12'hE3C);
    chk("R7 same-cycle other channel ch A", code_a, 12'h311);
  endtask

  task automatic t_full_scale();
    bus_cycle(1'b0, 1'b1, 2'b00, 8'hFF);
    bus_cycle(1'b0, 1'b0, 2'b01, 8'hFF);
    chk("R2 full scale ch A", code_a, 12'hFFF);
  endtask

  task automatic t_async_clear();
    @(negedge clk);
    sel_n = 1'b0; commit_n = 1'b0;
    #2 zero_n = 1'b0;
    #2;
    model_clear();
    chk_both("R8 clear without clock edge");
    @(negedge clk);
    zero_n = 1'b1; sel_n = 1'b1; commit_n = 1'b1;
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    chk_both("R8 staging cleared");
  endtask

  task automatic t_sync_reset();
    bus_cycle(1'b0, 1'b1, 2'b10, 8'h5A);
    bus_cycle(1'b0, 1'b0, 2'b11, 8'h07);
    chk("R1 ch B before reset", code_b, 12'h75A);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_clear();
    chk_both("R9 reset clears outputs");
    bus_cycle(1'b1, 1'b0, 2'b00, 8'h00);
    chk_both("R9 reset clears staging");
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_staged_then_commit();
    t_select_high();
    t_strobe_idle();
    t_held_strobe();
    t_combined();
    t_full_scale();
    t_async_clear();
    t_sync_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule